// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Unit

This unit is the multicycle arithmetic engine beside a small 8/16-bit core. It works on four 16-bit register pairs (AX, BC, DE, HL) and a 32-bit accumulator. The core presents the current register values, an operation code and a one-cycle start pulse. The unit latches the operands and runs for a fixed number of cycles that depends on the operation. It then updates its register outputs and pulses done for one cycle.

The operations are:
- an 8x8 unsigned multiply, A times X, where A is the upper byte of AX and X the lower;
- signed and unsigned 16x16 multiplies of AX by BC;
- signed and unsigned multiply-accumulates of AX times BC into the accumulator;
- an unsigned 16-bit divide of AX by DE;
- an unsigned 32-bit divide of BC:AX by HL:DE.

Divide by zero gives a defined result. The accumulate operations also produce a carry flag and an auxiliary-carry flag. Instruction decode and memory access stay in the core.

Top module: `mdu_top`

## Requirements
- R1: After reset all register outputs, both flags, busy_o and done_o are 0.
- R2: Operation code 0 writes the 16-bit product of AX[15:8] and AX[7:0] to AX. done_o rises 1 cycle after the start edge. BC, DE, HL and the accumulator outputs equal the values sampled at start.
- R3: Operation codes 1 (signed) and 2 (unsigned) multiply AX by BC. The upper product half goes to BC and the lower half to AX, with done_o 2 cycles after start.
- R4: Operation code 3 adds the signed product AX*BC to the accumulator, modulo 2^32, with done_o 3 cycles after start. Carry is set when bit 31 of the accumulator changed. Auxiliary carry equals the new bit 31.
- R5: Operation code 4 adds the unsigned product AX*BC to the accumulator, with done_o 3 cycles after start. Carry is set when the new accumulator is below the old one. Auxiliary carry is cleared.
- R6: Operation code 5 divides AX by a nonzero DE. The quotient goes to AX and the remainder to DE, with done_o 9 cycles after start.
- R7: Operation code 5 with DE = 0 gives AX = 0xFFFF and DE = the dividend.
- R8: Operation code 6 divides BC:AX by a nonzero HL:DE, where the first-named register is the upper half. The quotient goes to BC:AX and the remainder to HL:DE, with done_o 17 cycles after start.
- R9: Operation code 6 with HL:DE = 0 gives BC:AX = 0xFFFFFFFF and HL:DE = the dividend.
- R10: A start while busy_o is high is ignored, and the running operation completes unchanged. done_o is high for exactly one cycle per accepted operation.
- R11: The flags keep their values across operations other than codes 3 and 4. A start with the reserved code 7 is ignored: no busy, no done, and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when not busy |
| op_i | input | 3 | Operation code |
| ax_i | input | 16 | AX register value |
| bc_i | input | 16 | BC register value |
| de_i | input | 16 | DE register value |
| hl_i | input | 16 | HL register value |
| acc_i | input | 32 | Accumulator value |
| ax_o | output | 16 | Updated AX |
| bc_o | output | 16 | Updated BC |
| de_o | output | 16 | Updated DE |
| hl_o | output | 16 | Updated HL |
| acc_o | output | 32 | Updated accumulator |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary-carry flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that start_i and op_i are known values at every sampling edge. They also assume the register inputs only need to be valid in the start cycle, because the unit reads them nowhere else. The bench changes inputs only on falling edges and drops start after one cycle, except in the deliberate busy-overlap test. It varies the register inputs an operation does not use, so that outputs which should pass through are checked against values that differ from run to run.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL8 = 3'd0,
    OP_MULS = 3'd1,
    OP_MULU = 3'd2,
    OP_MACS = 3'd3,
    OP_MACU = 3'd4,
    OP_DIVH = 3'd5,
    OP_DIVW = 3'd6,
    OP_RSVD = 3'd7
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  mdu_op_e         op_i,
  input  logic [DW-1:0]   ax_i,
  input  logic [DW-1:0]   bc_i,
  input  logic [2*DW-1:0] acc_i,
  output logic [DW-1:0]   lo_o,
  output logic [DW-1:0]   hi_o,
  output logic [2*DW-1:0] acc_o,
  output logic            cy_o,
  output logic            ac_o
);
  localparam int W = 2 * DW;
  localparam int HB = DW / 2;

  logic signed [W-1:0] sprod;
  logic [W-1:0]        uprod;
  logic [DW-1:0]       p8;

  assign sprod = $signed({{DW{ax_i[DW-1]}}, ax_i}) * $signed({{DW{bc_i[DW-1]}}, bc_i});
  assign uprod = {{DW{1'b0}}, ax_i} * {{DW{1'b0}}, bc_i};
  assign p8    = {{HB{1'b0}}, ax_i[DW-1:HB]} * {{HB{1'b0}}, ax_i[HB-1:0]};

  always_comb begin
    lo_o  = ax_i;
    hi_o  = bc_i;
    acc_o = acc_i;
    cy_o  = 1'b0;
    ac_o  = 1'b0;
    unique case (op_i)
      OP_MUL8: lo_o = p8;
      OP_MULS: {hi_o, lo_o} = sprod;
      OP_MULU: {hi_o, lo_o} = uprod;
      OP_MACS: begin
        acc_o = acc_i + sprod;
        cy_o  = acc_i[W-1] ^ acc_o[W-1];
        ac_o  = acc_o[W-1];
      end
      OP_MACU: begin
        acc_o = acc_i + uprod;
        cy_o  = acc_o < acc_i;
        ac_o  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W  = 32,
  parameter int RB = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         wide_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int H = W / 2;

  logic [W-1:0] rem_q, dq_q, quo_q, dv_q;
  logic [W-1:0] rem_n, dq_n, quo_n;

  // RB restoring subtract stages per cycle
  always_comb begin
    logic [W:0] t;
    rem_n = rem_q;
    dq_n  = dq_q;
    quo_n = quo_q;
    for (int i = 0; i < RB; i++) begin
      t    = {rem_n, dq_n[W-1]};
      dq_n = {dq_n[W-2:0], 1'b0};
      if (t >= {1'b0, dv_q}) begin
        rem_n = W'(t - {1'b0, dv_q});
        quo_n = {quo_n[W-2:0], 1'b1};
      end else begin
        rem_n = t[W-1:0];
        quo_n = {quo_n[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dq_q  <= '0;
      quo_q <= '0;
      dv_q  <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= '0;
      dq_q  <= wide_i ? dividend_i : {dividend_i[H-1:0], {H{1'b0}}};
      dv_q  <= wide_i ? divisor_i : {{H{1'b0}}, divisor_i[H-1:0]};
    end else if (step_i) begin
      rem_q <= rem_n;
      dq_q  <= dq_n;
      quo_q <= quo_n;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  p_div_rem_below_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_q != '0) |-> (rem_q < dv_q));
  p_div_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !load_i);
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int DW      = 16,
  parameter int RB      = 2,
  parameter int LAT_M8  = 1,
  parameter int LAT_M16 = 2,
  parameter int LAT_MAC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [DW-1:0]   ax_i,
  input  logic [DW-1:0]   bc_i,
  input  logic [DW-1:0]   de_i,
  input  logic [DW-1:0]   hl_i,
  input  logic [2*DW-1:0] acc_i,
  output logic [DW-1:0]   ax_o,
  output logic [DW-1:0]   bc_o,
  output logic [DW-1:0]   de_o,
  output logic [DW-1:0]   hl_o,
  output logic [2*DW-1:0] acc_o,
  output logic            cy_o,
  output logic            ac_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int W      = 2 * DW;
  localparam int LAT_DH = DW / RB + 1;
  localparam int LAT_DW = W / RB + 1;
  localparam int CW     = $clog2(LAT_DW + 1);

  mdu_op_e          op_n, op_q;
  logic [DW-1:0]    src_ax_q, src_bc_q, src_de_q, src_hl_q;
  logic [W-1:0]     src_acc_q;
  logic [CW-1:0]    cnt_q;
  logic             accept, div_load, div_step, finish;
  logic [DW-1:0]    mul_lo, mul_hi;
  logic [W-1:0]     mac_acc, quo, rem;
  logic             mac_cy, mac_ac;

  function automatic logic [CW-1:0] lat_of(mdu_op_e op);
    case (op)
      OP_MUL8:          return CW'(LAT_M8);
      OP_MULS, OP_MULU: return CW'(LAT_M16);
      OP_MACS, OP_MACU: return CW'(LAT_MAC);
      OP_DIVH:          return CW'(LAT_DH);
      OP_DIVW:          return CW'(LAT_DW);
      default:          return CW'(1);
    endcase
  endfunction

  assign op_n     = mdu_op_e'(op_i);
  assign accept   = start_i && !busy_o && (op_n != OP_RSVD);
  assign div_load = accept && (op_n == OP_DIVH || op_n == OP_DIVW);
  assign finish   = busy_o && (cnt_q == CW'(1));
  assign div_step = busy_o && !finish && (op_q == OP_DIVH || op_q == OP_DIVW);

  mdu_mul #(.DW(DW)) u_mul (
    .op_i  (op_q),
    .ax_i  (src_ax_q),
    .bc_i  (src_bc_q),
    .acc_i (src_acc_q),
    .lo_o  (mul_lo),
    .hi_o  (mul_hi),
    .acc_o (mac_acc),
    .cy_o  (mac_cy),
    .ac_o  (mac_ac)
  );

  mdu_div #(.W(W), .RB(RB)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (div_load),
    .step_i     (div_step),
    .wide_i     (op_n == OP_DIVW),
    .dividend_i ({bc_i, ax_i}),
    .divisor_i  ({hl_i, de_i}),
    .quo_o      (quo),
    .rem_o      (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_MUL8;
      src_ax_q  <= '0;
      src_bc_q  <= '0;
      src_de_q  <= '0;
      src_hl_q  <= '0;
      src_acc_q <= '0;
      cnt_q     <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      ax_o      <= '0;
      bc_o      <= '0;
      de_o      <= '0;
      hl_o      <= '0;
      acc_o     <= '0;
      cy_o      <= 1'b0;
      ac_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        op_q      <= op_n;
        src_ax_q  <= ax_i;
        src_bc_q  <= bc_i;
        src_de_q  <= de_i;
        src_hl_q  <= hl_i;
        src_acc_q <= acc_i;
        cnt_q     <= lat_of(op_n);
        busy_o    <= 1'b1;
      end else if (finish) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        cnt_q  <= '0;
        ax_o   <= src_ax_q;
        bc_o   <= src_bc_q;
        de_o   <= src_de_q;
        hl_o   <= src_hl_q;
        acc_o  <= src_acc_q;
        unique case (op_q)
          OP_MUL8, OP_MULS, OP_MULU: begin
            ax_o <= mul_lo;
            bc_o <= mul_hi;
          end
          OP_MACS, OP_MACU: begin
            acc_o <= mac_acc;
            cy_o  <= mac_cy;
            ac_o  <= mac_ac;
          end
          OP_DIVH: begin
            ax_o <= quo[DW-1:0];
            de_o <= rem[DW-1:0];
          end
          OP_DIVW: begin
            {bc_o, ax_o} <= quo;
            {hl_o, de_o} <= rem;
          end
          default: ;
        endcase
      end else if (busy_o) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  p_done_after_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (op_q == $past(op_q)));
  p_busy_has_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0));
  p_flags_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q != OP_MACS && op_q != OP_MACU) |-> ($stable(cy_o) && $stable(ac_o)));
  p_macu_ac_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_MACU) |-> !ac_o);
  p_divh_identity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DIVH && src_de_q != '0) |->
      (({{DW{1'b0}}, ax_o} * {{DW{1'b0}}, src_de_q} + {{DW{1'b0}}, de_o}) == {{DW{1'b0}}, src_ax_q}
       && de_o < src_de_q));
  p_divh_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DIVH && src_de_q == '0) |-> (ax_o == '1 && de_o == src_ax_q));
  p_divw_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DIVW && {src_hl_q, src_de_q} == '0) |->
      ({bc_o, ax_o} == '1 && {hl_o, de_o} == {src_bc_q, src_ax_q}));
endmodule

// File: tb/mdu_top_tb.sv
`timescale 1ns/1ps
module mdu_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] ax_i = '0, bc_i = '0, de_i = '0, hl_i = '0;
  logic [31:0] acc_i = '0;
  logic [15:0] ax_o, bc_o, de_o, hl_o;
  logic [31:0] acc_o;
  logic        cy_o, ac_o, busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic cy_m = 1'b0, ac_m = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mdu_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .ax_i(ax_i), .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i), .acc_i(acc_i),
    .ax_o(ax_o), .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .acc_o(acc_o),
    .cy_o(cy_o), .ac_o(ac_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lat_exp(input logic [2:0] op);
    case (op)
      3'd0: return 1;
      3'd1, 3'd2: return 2;
      3'd3, 3'd4: return 3;
      3'd5: return 9;
      default: return 17;
    endcase
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [15:0] a, b, d, h, input logic [31:0] acc);
    logic [15:0] e_ax, e_bc, e_de, e_hl;
    logic [31:0] e_acc, p, dd, dv;
    logic signed [31:0] sp;
    logic [32:0] sum;
    string req;
    int cyc;
    e_ax = a; e_bc = b; e_de = d; e_hl = h; e_acc = acc;
    dd = {b, a}; dv = {h, d};
    case (op)
      3'd0: begin req = "R2"; e_ax = 16'(a[15:8] * a[7:0]); end
      3'd1: begin req = "R3"; sp = $signed(a) * $signed(b); {e_bc, e_ax} = sp; end
      3'd2: begin req = "R3"; p = {16'h0, a} * {16'h0, b}; {e_bc, e_ax} = p; end
      3'd3: begin
        req = "R4"; sp = $signed(a) * $signed(b); e_acc = acc + sp;
        cy_m = acc[31] ^ e_acc[31]; ac_m = e_acc[31];
      end
      3'd4: begin
        req = "R5"; p = {16'h0, a} * {16'h0, b}; sum = {1'b0, acc} + {1'b0, p};
        e_acc = sum[31:0]; cy_m = sum[32]; ac_m = 1'b0;
      end
      3'd5: begin
        if (d == 0) begin req = "R7"; e_ax = 16'hFFFF; e_de = a; end
        else begin req = "R6"; e_ax = a / d; e_de = a % d; end
      end
      default: begin
        if (dv == 0) begin req = "R9"; {e_bc, e_ax} = 32'hFFFF_FFFF; {e_hl, e_de} = dd; end
        else begin req = "R8"; {e_bc, e_ax} = dd / dv; {e_hl, e_de} = dd % dv; end
      end
    endcase
    @(negedge clk_i);
    op_i = op; ax_i = a; bc_i = b; de_i = d; hl_i = h; acc_i = acc; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    ax_i = ~a; bc_i = ~b; de_i = ~d; hl_i = ~h; acc_i = ~acc;
    cyc = 0;
    while (!done_o && cyc < 40) begin
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
    end
    chk({req, " latency"}, 32'(cyc), 32'(lat_exp(op)));
    chk({req, " ax"}, {16'h0, ax_o}, {16'h0, e_ax});
    chk({req, " bc"}, {16'h0, bc_o}, {16'h0, e_bc});
    chk({req, " de"}, {16'h0, de_o}, {16'h0, e_de});
    chk({req, " hl"}, {16'h0, hl_o}, {16'h0, e_hl});
    chk({req, " acc"}, acc_o, e_acc);
    chk({req, " R11 cy"}, {31'h0, cy_o}, {31'h0, cy_m});
    chk({req, " R11 ac"}, {31'h0, ac_o}, {31'h0, ac_m});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ds [0:8];
    logic [15:0] nn [0:5];
    int cyc;
    ds = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd7, 16'd255, 16'd256, 16'h7FFF, 16'hFFFF};
    nn = '{16'd0, 16'd1, 16'd5, 16'h1234, 16'h8000, 16'hFFFF};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 ax", {16'h0, ax_o}, 32'h0);
    chk("R1 bc", {16'h0, bc_o}, 32'h0);
    chk("R1 de", {16'h0, de_o}, 32'h0);
    chk("R1 hl", {16'h0, hl_o}, 32'h0);
    chk("R1 acc", acc_o, 32'h0);
    chk("R1 flags", {30'h0, cy_o, ac_o}, 32'h0);
    chk("R1 busy/done", {30'h0, busy_o, done_o}, 32'h0);

    // R2 sweep of A and X
    for (int a = 0; a < 256; a += 15)
      for (int x = 0; x < 256; x += 15)
        do_op(3'd0, {a[7:0], x[7:0]}, 16'($urandom), 16'($urandom), 16'($urandom), $urandom);

    // R3 corners and random
    do_op(3'd1, 16'h8000, 16'h8000, 16'h1, 16'h2, 32'h3);
    do_op(3'd1, 16'hFFFF, 16'h0001, 16'h1, 16'h2, 32'h3);
    do_op(3'd2, 16'hFFFF, 16'hFFFF, 16'h1, 16'h2, 32'h3);
    for (int i = 0; i < 150; i++) begin
      do_op(3'd1, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), $urandom);
      do_op(3'd2, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), $urandom);
    end

    // R4 / R5 corners and random
    do_op(3'd3, 16'd1, 16'd1, 16'h0, 16'h0, 32'h7FFF_FFFF);
    do_op(3'd3, 16'hFFFF, 16'd1, 16'h0, 16'h0, 32'h0);
    do_op(3'd4, 16'd1, 16'd1, 16'h0, 16'h0, 32'hFFFF_FFFF);
    do_op(3'd4, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 32'h0000_0001);
    for (int i = 0; i < 150; i++) begin
      do_op(3'd3, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), $urandom);
      do_op(3'd4, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), $urandom);
    end

    // R11 flags held across non-accumulate ops
    do_op(3'd4, 16'd1, 16'd1, 16'h0, 16'h0, 32'hFFFF_FFFF);
    do_op(3'd1, 16'h1234, 16'h5678, 16'h0, 16'h0, 32'h0);
    do_op(3'd5, 16'd100, 16'h0, 16'd9, 16'h0, 32'h0);

    // R6 / R7 grid and random
    foreach (nn[i])
      foreach (ds[j])
        do_op(3'd5, nn[i], 16'($urandom), ds[j], 16'($urandom), $urandom);
    for (int i = 0; i < 150; i++)
      do_op(3'd5, 16'($urandom), 16'($urandom), 16'($urandom >> (i % 16)), 16'($urandom), $urandom);

    // R8 / R9 corners and random
    do_op(3'd6, 16'h5678, 16'h1234, 16'h0, 16'h0, 32'h0);
    do_op(3'd6, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 32'h0);
    do_op(3'd6, 16'hFFFF, 16'hFFFF, 16'h1, 16'h0, 32'h0);
    do_op(3'd6, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'h0);
    do_op(3'd6, 16'h0000, 16'h8000, 16'h0003, 16'h0000, 32'h0);
    for (int i = 0; i < 120; i++)
      do_op(3'd6, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom >> (i % 17)), $urandom);

    // R10 start while busy is ignored
    @(negedge clk_i);
    op_i = 3'd5; ax_i = 16'd100; de_i = 16'd7; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 busy", {31'h0, busy_o}, 32'h1);
    op_i = 3'd0; ax_i = 16'h0303; de_i = 16'd1;
    cyc = 0;
    while (!done_o && cyc < 40) begin
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
      if (cyc == 3) start_i = 1'b0;
    end
    start_i = 1'b0;
    chk("R10 latency", 32'(cyc), 32'd9);
    chk("R10 ax", {16'h0, ax_o}, 32'd14);
    chk("R10 de", {16'h0, de_o}, 32'd2);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 done one cycle", {30'h0, done_o, busy_o}, 32'h0);

    // R11 reserved code ignored
    begin
      logic [15:0] ax_prev;
      logic [31:0] acc_prev;
      int seen;
      ax_prev = ax_o; acc_prev = acc_o; seen = 0;
      op_i = 3'd7; ax_i = 16'hABCD; acc_i = 32'h1111_2222; start_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      chk("R11 reserved busy", {31'h0, busy_o}, 32'h0);
      for (int k = 0; k < 4; k++) begin
        if (done_o) seen++;
        @(posedge clk_i);
        @(negedge clk_i);
      end
      chk("R11 reserved done", 32'(seen), 32'h0);
      chk("R11 reserved ax", {16'h0, ax_o}, {16'h0, ax_prev});
      chk("R11 reserved acc", acc_o, acc_prev);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule